// File: doc/BRIEF.md
# Shared Floppy Controller Bank Glue

This block sits between a byte-wide host I/O bus and one floppy disk controller core. The core is reachable through two groups of three ports: a high-density group at 0x90/0x92/0x94 and a double-density group at 0xC8/0xCA/0xCC. Each group has a status port, a data port and a control port. Bit 0 of a mode register at 0xBE picks which group is live. Accesses to the status and data ports of the live group pass straight through to the core. The same accesses to the other group do not reach the core.

The block keeps a control register and a mode register. From them it drives the core's reset strobe, its ready input and a per-drive density indication for drives 0 and 1. It steers the core's interrupt and DMA request to one of two interrupt lines and one of two DMA channels. A retriggerable one-shot timer can post an interrupt when it expires. The core, the DMA engine and the interrupt controller are outside the block and appear only as ports.

Top module: `fdc_bank_glue`

## Requirements
- R1: After reset the control register holds 0x80 and the mode register holds 0x03. Both drive density outputs are 1 (high density), the ready output is 0 and no timer is running.
- R2: Status ports (0x90, 0xC8) and data ports (0x92, 0xCA) forward a read or write to the core only when address bit 4 equals mode bit 0. fdcA0 is 0 for status ports and 1 for data ports, and the read data comes from fdcRdData.
- R3: A write to the live control port raises fdcReset for exactly one cycle after the write edge. This happens only if bit 7 of the written byte is 1 and bit 7 of the stored control value is 0.
- R4: A write to the live control port copies bit 6 into fdcReady. A write to 0xCC with bit 5 clear leaves fdcReady unchanged.
- R5: A write to the control port of the group that is not live has no effect. It does not pulse fdcReset, it does not change fdcReady and it does not start the timer.
- R6: A live control write with bit 0 set starts a one-shot timer of CLK_HZ/1e6*TIMEOUT_US cycles. When the timer expires, intr2 pulses for one cycle, TICKS cycles after the write edge, provided control bit 2 is set at that time.
- R7: A start while the timer is running restarts it from the full count, and the earlier expiry produces no pulse.
- R8: If control bit 2 is clear when the timer expires, no interrupt pulse is produced.
- R9: With mode bit 0 = 1, fdcIrq appears on intr3 and fdcDrq on drq2. With mode bit 0 = 0, they appear on intr2 and drq3. The line that is not selected stays 0.
- R10: A mode write that takes bit 1 from 0 to 1 sets both drive density outputs to 1. A write that takes it from 1 to 0 clears them. Any other mode write leaves them unchanged.
- R11: A read of 0xBE returns 0xF8 OR mode bits [1:0]. A read of 0x94 returns 0x44 when mode bit 0 is 1 and 0xFF otherwise.
- R12: A read of 0xCC returns 0x64 OR (0x10 when diskIn is 1) when mode bit 0 is 0, and 0xFF otherwise. Every undecoded address, and every status or data port of the group that is not live, reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Host I/O byte address |
| busWrData | input | DATA_W | Host write data |
| busWr | input | 1 | Host write strobe, one cycle per write |
| busRd | input | 1 | Host read strobe |
| busRdData | output | DATA_W | Read data for the current address |
| fdcSel | output | 1 | Core access select |
| fdcA0 | output | 1 | Core register select (0 status, 1 data) |
| fdcWr | output | 1 | Core write strobe |
| fdcRd | output | 1 | Core read strobe |
| fdcWrData | output | DATA_W | Write data to the core |
| fdcRdData | input | DATA_W | Read data from the core |
| fdcReset | output | 1 | One-cycle core reset pulse |
| fdcReady | output | 1 | Core ready input |
| driveHd | output | 2 | Density of drives 0 and 1 (1 = high density) |
| fdcIrq | input | 1 | Core interrupt request |
| fdcDrq | input | 1 | Core DMA request |
| diskIn | input | 1 | Disk-inserted indication |
| intr2 | output | 1 | Interrupt line 2 (double-density group and timer) |
| intr3 | output | 1 | Interrupt line 3 (high-density group) |
| drq2 | output | 1 | DMA channel 2 request |
| drq3 | output | 1 | DMA channel 3 request |

## Verification
The bench builds the block with CLK_HZ set to 1 MHz and TIMEOUT_US set to 40, so the one-shot lasts 40 cycles instead of five million. At that length the bench can sample the exact expiry cycle, restart the timer partway through its count and confirm the suppressed pulse within a short run. Address and data widths stay at their defaults of 16 and 8, so every port address is decoded exactly as on the real bus.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CORE,
    RD_HDCTL,
    RD_MODE,
    RD_DDCTL
  } rdSrc_e;

  typedef struct packed {
    logic   ctrlWr;
    logic   readyWr;
    logic   modeWr;
    logic   coreHit;
    logic   coreA0;
    rdSrc_e rdSrc;
  } glueStrobe_t;

endpackage

// File: rtl/fdc_glue_ctrl.sv
module fdc_glue_ctrl
  import fdc_glue_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              wrBit5,
  input  logic              bankSel,
  output glueStrobe_t       strb
);

  localparam logic [ADDR_W-1:0] HdStat = ADDR_W'(8'h90);
  localparam logic [ADDR_W-1:0] HdData = ADDR_W'(8'h92);
  localparam logic [ADDR_W-1:0] HdCtl  = ADDR_W'(8'h94);
  localparam logic [ADDR_W-1:0] DdStat = ADDR_W'(8'hC8);
  localparam logic [ADDR_W-1:0] DdData = ADDR_W'(8'hCA);
  localparam logic [ADDR_W-1:0] DdCtl  = ADDR_W'(8'hCC);
  localparam logic [ADDR_W-1:0] ModeA  = ADDR_W'(8'hBE);

  logic isStat, isData, isCtl, isMode, bankLive;

  always_comb begin
    isStat   = (busAddr == HdStat) || (busAddr == DdStat);
    isData   = (busAddr == HdData) || (busAddr == DdData);
    isCtl    = (busAddr == HdCtl)  || (busAddr == DdCtl);
    isMode   = (busAddr == ModeA);
    bankLive = (busAddr[4] == bankSel);

    strb.coreHit = (isStat || isData) && bankLive && (busWr || busRd);
    strb.coreA0  = isData;
    strb.ctrlWr  = busWr && isCtl && bankLive;
    strb.readyWr = strb.ctrlWr && !((busAddr == DdCtl) && !wrBit5);
    strb.modeWr  = busWr && isMode;

    if ((isStat || isData) && bankLive)      strb.rdSrc = RD_CORE;
    else if ((busAddr == HdCtl) && bankSel)  strb.rdSrc = RD_HDCTL;
    else if (isMode)                         strb.rdSrc = RD_MODE;
    else if ((busAddr == DdCtl) && !bankSel) strb.rdSrc = RD_DDCTL;
    else                                     strb.rdSrc = RD_NONE;
  end

endmodule

// File: rtl/fdc_glue_timer.sv
module fdc_glue_timer #(
  parameter int TICKS = 5_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic armIrq,
  output logic expirePulse
);

  localparam int CNT_W = $clog2(TICKS + 1);

  logic             running;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running     <= 1'b0;
      cnt         <= '0;
      expirePulse <= 1'b0;
    end else begin
      expirePulse <= running && (cnt == '0) && !start && armIrq;
      if (start) begin
        running <= 1'b1;
        cnt     <= CNT_W'(TICKS - 1);
      end else if (running) begin
        if (cnt == '0) running <= 1'b0;
        else           cnt     <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/fdc_glue_dp.sv
module fdc_glue_dp
  import fdc_glue_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  glueStrobe_t       strb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] fdcRdData,
  input  logic              diskIn,
  input  logic              fdcIrq,
  input  logic              fdcDrq,
  input  logic              timerPulse,
  output logic [DATA_W-1:0] ctrlQ,
  output logic [DATA_W-1:0] modeQ,
  output logic              fdcReset,
  output logic              fdcReady,
  output logic [1:0]        driveHd,
  output logic [DATA_W-1:0] busRdData,
  output logic              intr2,
  output logic              intr3,
  output logic              drq2,
  output logic              drq3
);

  localparam logic [DATA_W-1:0] CtlRst   = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] ModeRst  = DATA_W'(8'h03);
  localparam logic [DATA_W-1:0] HdStatRd = DATA_W'(8'h44);
  localparam logic [DATA_W-1:0] DdStatRd = DATA_W'(8'h64);
  localparam logic [DATA_W-1:0] DiskBit  = DATA_W'(8'h10);
  localparam logic [DATA_W-1:0] ModeFill = DATA_W'(8'hF8);
  localparam logic [DATA_W-1:0] Idle     = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= CtlRst;
      modeQ    <= ModeRst;
      fdcReset <= 1'b0;
      fdcReady <= 1'b0;
      driveHd  <= 2'b11;
    end else begin
      fdcReset <= strb.ctrlWr && !ctrlQ[7] && busWrData[7];
      if (strb.ctrlWr)  ctrlQ    <= busWrData;
      if (strb.readyWr) fdcReady <= busWrData[6];
      if (strb.modeWr) begin
        modeQ <= busWrData;
        if (!modeQ[1] && busWrData[1])      driveHd <= 2'b11;
        else if (modeQ[1] && !busWrData[1]) driveHd <= 2'b00;
      end
    end
  end

  always_comb begin
    unique case (strb.rdSrc)
      RD_CORE:  busRdData = fdcRdData;
      RD_HDCTL: busRdData = HdStatRd;
      RD_MODE:  busRdData = ModeFill | {{(DATA_W-2){1'b0}}, modeQ[1:0]};
      RD_DDCTL: busRdData = DdStatRd | (diskIn ? DiskBit : '0);
      default:  busRdData = Idle;
    endcase
  end

  always_comb begin
    intr3 = fdcIrq && modeQ[0];
    intr2 = (fdcIrq && !modeQ[0]) || timerPulse;
    drq2  = fdcDrq && modeQ[0];
    drq3  = fdcDrq && !modeQ[0];
  end

endmodule

// File: rtl/fdc_bank_glue.sv
module fdc_bank_glue
  import fdc_glue_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_US = 100_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdData,
  output logic              fdcSel,
  output logic              fdcA0,
  output logic              fdcWr,
  output logic              fdcRd,
  output logic [DATA_W-1:0] fdcWrData,
  input  logic [DATA_W-1:0] fdcRdData,
  output logic              fdcReset,
  output logic              fdcReady,
  output logic [1:0]        driveHd,
  input  logic              fdcIrq,
  input  logic              fdcDrq,
  input  logic              diskIn,
  output logic              intr2,
  output logic              intr3,
  output logic              drq2,
  output logic              drq3
);

  localparam int TICKS = (CLK_HZ / 1_000_000) * TIMEOUT_US;

  glueStrobe_t       strb;
  logic [DATA_W-1:0] ctrlQ, modeQ;
  logic              timerPulse;

  fdc_glue_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .wrBit5  (busWrData[5]),
    .bankSel (modeQ[0]),
    .strb    (strb)
  );

  fdc_glue_timer #(.TICKS(TICKS)) u_timer (
    .clk         (clk),
    .rstN        (rstN),
    .start       (strb.ctrlWr && busWrData[0]),
    .armIrq      (ctrlQ[2]),
    .expirePulse (timerPulse)
  );

  fdc_glue_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWrData  (busWrData),
    .fdcRdData  (fdcRdData),
    .diskIn     (diskIn),
    .fdcIrq     (fdcIrq),
    .fdcDrq     (fdcDrq),
    .timerPulse (timerPulse),
    .ctrlQ      (ctrlQ),
    .modeQ      (modeQ),
    .fdcReset   (fdcReset),
    .fdcReady   (fdcReady),
    .driveHd    (driveHd),
    .busRdData  (busRdData),
    .intr2      (intr2),
    .intr3      (intr3),
    .drq2       (drq2),
    .drq3       (drq3)
  );

  assign fdcSel    = strb.coreHit;
  assign fdcA0     = strb.coreA0;
  assign fdcWr     = strb.coreHit && busWr;
  assign fdcRd     = strb.coreHit && busRd;
  assign fdcWrData = busWrData;

endmodule

// File: rtl/fdc_bank_glue_chk.sv
module fdc_bank_glue_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busWr,
  input logic [DATA_W-1:0] busRdData,
  input logic              fdcWr,
  input logic              fdcReset,
  input logic              fdcReady,
  input logic [1:0]        driveHd,
  input logic              fdcIrq,
  input logic              fdcDrq,
  input logic              intr3,
  input logic              drq2,
  input logic              drq3
);

  // R3
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    fdcReset |-> $past(busWr && busWrData[7]));

  // R3
  rst_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    fdcReset |=> !fdcReset);

  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busWr) |-> $stable(fdcReady));

  // R10
  density_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busWr && (busAddr == ADDR_W'(8'hBE))) |-> $stable(driveHd));

  // R9
  route_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    intr3 |-> fdcIrq);

  // R9
  route_drq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({drq2, drq3}) && ((drq2 || drq3) == fdcDrq));

  // R11
  mode_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(8'hBE)) |-> (busRdData[7:2] == 6'h3E));

  // R2
  core_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    fdcWr |-> busWr);

endmodule

bind fdc_bank_glue fdc_bank_glue_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/fdc_bank_glue_bench.sv
`timescale 1ns/1ps
module fdc_bank_glue_bench;

  localparam int TICKS = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busRdData, fdcWrData;
  logic [7:0]  fdcRdData = 8'h5A;
  logic        fdcSel, fdcA0, fdcWr, fdcRd, fdcReset, fdcReady;
  logic [1:0]  driveHd;
  logic        fdcIrq = 1'b0, fdcDrq = 1'b0, diskIn = 1'b0;
  logic        intr2, intr3, drq2, drq3;

  always #10 clk = ~clk;

  fdc_bank_glue #(.CLK_HZ(1_000_000), .TIMEOUT_US(TICKS)) u_fdc_bank_glue (.*);

  typedef struct {
    int    sel;
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  event  pushEv;
  int    nChk = 0, nFail = 0;
  bit    done = 0;

  function automatic int probeSig(int sel);
    case (sel)
      0:  return int'(busRdData);
      1:  return int'(fdcReset);
      2:  return int'(fdcReady);
      3:  return int'(driveHd);
      4:  return int'(intr2);
      5:  return int'(intr3);
      6:  return int'(drq2);
      7:  return int'(drq3);
      8:  return int'(fdcSel);
      9:  return int'(fdcA0);
      10: return int'(fdcWr);
      11: return int'(fdcRd);
      12: return int'(fdcWrData);
      default: return -1;
    endcase
  endfunction

  // monitor: pops expectations and compares against the live outputs
  initial begin
    forever begin
      @(pushEv);
      while (q.size() != 0) begin
        item_t it;
        int    got;
        it  = q.pop_front();
        got = probeSig(it.sel);
        nChk++;
        if (got != it.exp) begin
          nFail++;
          $display("FAIL %s sig%0d: actual %h expected %h", it.tag, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic expectSig(int sel, int exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
    ->pushEv;
  endtask

  task automatic scalarChk(int got, int exp, string tag);
    nChk++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic busWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readChk(logic [15:0] a, int exp, string tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 expectSig(0, exp, tag);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic coreProbe(logic [15:0] a, bit wr, int expSel, int expA0, string tag);
    @(negedge clk);
    busAddr = a; busWrData = 8'h33; busWr = wr; busRd = !wr;
    #1;
    expectSig(8, expSel, tag);
    if (expSel != 0) begin
      expectSig(9, expA0, tag);
      expectSig(wr ? 10 : 11, 1, tag);
      if (wr) expectSig(12, 8'h33, tag);
      else    expectSig(0, 8'h5A, tag);
    end else if (!wr) begin
      expectSig(0, 8'hFF, tag);
    end
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      #1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expectSig(3, 2'b11, "R1");
    expectSig(2, 0, "R1");
    expectSig(4, 0, "R1");
    expectSig(1, 0, "R1");
    readChk(16'h00BE, 8'hFB, "R1");
    readChk(16'h0094, 8'h44, "R11");

    // R2 forwarding gated by mode bit 0 (= 1: 0x9x group live)
    coreProbe(16'h0092, 0, 1, 1, "R2");
    coreProbe(16'h0090, 1, 1, 0, "R2");
    coreProbe(16'h00CA, 0, 0, 0, "R2");
    coreProbe(16'h00C8, 1, 0, 0, "R2");
    readChk(16'h0123, 8'hFF, "R12");

    // R3 reset pulse only on bit7 0->1 against stored value
    busWrite(16'h0094, 8'h80);
    expectSig(1, 0, "R3");
    busWrite(16'h0094, 8'h00);
    expectSig(1, 0, "R3");
    busWrite(16'h0094, 8'hC0);
    expectSig(1, 1, "R3");
    expectSig(2, 1, "R4");
    @(negedge clk);
    expectSig(1, 0, "R3");

    // R5 control write to the idle group is ignored
    busWrite(16'h0094, 8'h40);
    busWrite(16'h00CC, 8'hA1);
    expectSig(1, 0, "R5");
    expectSig(2, 1, "R5");
    repeat (TICKS + 2) @(negedge clk);
    expectSig(4, 0, "R5");
    readChk(16'h00CC, 8'hFF, "R12");

    // R10 / R11 / R12 switch to the 0xCx group
    busWrite(16'h00BE, 8'h00);
    expectSig(3, 2'b00, "R10");
    readChk(16'h00BE, 8'hF8, "R11");
    readChk(16'h0094, 8'hFF, "R11");
    diskIn = 1'b1;
    readChk(16'h00CC, 8'h74, "R12");
    diskIn = 1'b0;
    readChk(16'h00CC, 8'h64, "R12");
    coreProbe(16'h0090, 0, 0, 0, "R2");
    coreProbe(16'h00C8, 0, 1, 0, "R2");

    // R4 ready update rules on 0xCC
    busWrite(16'h00CC, 8'h00);
    expectSig(2, 1, "R4");
    busWrite(16'h00CC, 8'h20);
    expectSig(2, 0, "R4");
    busWrite(16'h00CC, 8'hA0);
    expectSig(1, 1, "R3");

    // R9 routing with mode bit 0 = 0
    fdcIrq = 1'b1; fdcDrq = 1'b1;
    #1;
    expectSig(4, 1, "R9"); expectSig(5, 0, "R9");
    expectSig(7, 1, "R9"); expectSig(6, 0, "R9");
    busWrite(16'h00BE, 8'h03);
    expectSig(3, 2'b11, "R10");
    expectSig(4, 0, "R9"); expectSig(5, 1, "R9");
    expectSig(6, 1, "R9"); expectSig(7, 0, "R9");
    busWrite(16'h00BE, 8'h02);
    expectSig(3, 2'b11, "R10");
    fdcIrq = 1'b0; fdcDrq = 1'b0;
    #1;
    expectSig(4, 0, "R9");

    // R6 one-shot expiry timing
    busWrite(16'h00CC, 8'h25);
    repeat (TICKS - 1) @(negedge clk);
    expectSig(4, 0, "R6");
    @(negedge clk);
    expectSig(4, 1, "R6");
    @(negedge clk);
    expectSig(4, 0, "R6");

    // R7 retrigger
    busWrite(16'h00CC, 8'h25);
    repeat (20) @(negedge clk);
    busWrite(16'h00CC, 8'h25);
    begin
      int hits = 0;
      for (int i = 0; i < TICKS - 1; i++) begin
        @(negedge clk);
        if (intr2) hits++;
      end
      scalarChk(hits, 0, "R7");
    end
    @(negedge clk);
    expectSig(4, 1, "R7");

    // R8 expiry with bit 2 clear posts nothing
    busWrite(16'h00CC, 8'h21);
    begin
      int hits = 0;
      for (int i = 0; i < TICKS + 3; i++) begin
        @(negedge clk);
        if (intr2) hits++;
      end
      scalarChk(hits, 0, "R8");
    end

    #5;
    finishRun();
  end

endmodule